// File: doc/BRIEF.md
# Systolic Hankel Matrix-Vector Multiplier over GF(2)

This block forms the product of a square Hankel matrix and a bit vector over GF(2). The matrix is never stored in full. It is described by its generating vector `hvec` of 2D-1 bits, and entry (row k, column p) of the matrix equals `hvec[k+p]`, so every anti-diagonal holds a single value. The other operand is the D-bit vector `bvec`. Each product bit is the exclusive-OR, over all j, of `hvec[i+j] AND bvec[j]`.

The work is done by a D-by-D grid of identical bit cells, each with one AND gate and one XOR gate. Each column of cells owns one register stage for the partial sums. The operands travel down a skew line so that column c sees the operand pair that entered c cycles earlier. Within a column, row i taps operand index sigma(i,c), a folding map that depends on parity. When i+c is even the index is (c-i)/2 mod D. When i+c is odd it is -(c+i+1)/2 mod D. This keeps every cell's wiring to a short local pattern.

The pipeline is full, so an operand pair can be presented on every clock. A valid flag travels with the data and marks the matching result D cycles later. Field reduction and basis conversion belong to the surrounding logic.

Top module: `hankel_systolic_mul`

## Requirements
- R1: While `rst_n` is low, and after release until the first result comes out, `out_valid` is 0 and `prod` is all zero, provided `hvec` and `bvec` are held at zero.
- R2: For an operand pair taken with `in_valid` high, `prod[i]` equals the XOR over j = 0..D-1 of `hvec[i+j] & bvec[j]`. Bit 0 of each vector is its LSB.
- R3: A pair presented with `in_valid` high in clock cycle n gives its result on `prod` together with `out_valid` = 1 in cycle n+D, with no other delay.
- R4: Operand pairs presented on consecutive cycles give their results on consecutive cycles, in the same order and without interference.
- R5: `out_valid` is 0 in any cycle whose cycle D earlier had `in_valid` low, including across gaps in the input stream.
- R6: An all-zero `bvec` gives an all-zero `prod`, whatever `hvec` holds.
- R7: An all-zero `hvec` gives an all-zero `prod`, whatever `bvec` holds.
- R8: With `hvec` all ones, every product bit equals the parity of the number of ones in `bvec`. If `bvec` is also all ones, every bit is D mod 2.
- R9: With only `hvec[k]` and `bvec[j]` set, `prod` has exactly bit k-j set when 0 <= k-j < D, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the operand pair on `hvec` and `bvec` as a job |
| hvec | input | 2D-1 | Hankel generating vector; matrix entry (k,p) is `hvec[k+p]` |
| bvec | input | D | Vector operand |
| out_valid | output | 1 | High in the cycle that `prod` carries a result |
| prod | output | D | Product vector |

## Verification
The hardest case to reach from the ports is a set of operand pairs with different data in flight at once, where each column of the grid works on a different job. Only then would a wrong skew depth or a wrong fold-map tap mix bits from neighbouring jobs. The stimulus reaches this with long back-to-back runs of random pairs, and then with randomly gapped runs where invalid cycles carry random data. Single-bit operand pairs, swept over every position of both vectors, tie each product bit to one exact anti-diagonal, so any misplaced tap in any cell shows up.

// File: rtl/hkl_pkg.sv
package hkl_pkg;

    // Operand index visited by the cell in row r, column c of a size-n grid.
    function automatic int fold_idx(input int r, input int c, input int n);
        int q;
        if (((r + c) % 2) == 0) begin
            q = (c - r) / 2;
        end else begin
            q = -((c + r + 1) / 2);
        end
        return ((q % n) + n) % n;
    endfunction

endpackage

// File: rtl/hkl_cell.sv
module hkl_cell (
    input  logic sum_in,
    input  logic op_b,
    input  logic op_h,
    output logic sum_out
);

    always_comb begin
        sum_out = sum_in ^ (op_b & op_h);
    end

endmodule

// File: rtl/hkl_skew.sv
module hkl_skew #(
    parameter int W     = 23,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [W-1:0]               din,
    output logic [DEPTH-1:0][W-1:0]    taps
);

    localparam int STAGES = DEPTH - 1;

    logic [STAGES-1:0][W-1:0] stg_d;
    logic [STAGES-1:0][W-1:0] stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign taps[0] = din;

    generate
        for (genvar t = 1; t < DEPTH; t++) begin : g_tap
            assign taps[t] = stg_q[t-1];
        end
    endgenerate

endmodule

// File: rtl/hkl_column.sv
module hkl_column
    import hkl_pkg::*;
#(
    parameter int D   = 8,
    parameter int COL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*D-2:0]   h_in,
    input  logic [D-1:0]     b_in,
    input  logic [D-1:0]     sum_in,
    output logic [D-1:0]     sum_out
);

    typedef struct packed {
        logic [D-1:0] sum;
    } col_state_t;

    col_state_t   st_d;
    col_state_t   st_q;
    logic [D-1:0] cell_sum;
    logic         unused_hbits;

    assign unused_hbits = ^h_in;

    generate
        for (genvar r = 0; r < D; r++) begin : g_row
            localparam int SIG = fold_idx(r, COL, D);
            hkl_cell u_cell (
                .sum_in  (sum_in[r]),
                .op_b    (b_in[SIG]),
                .op_h    (h_in[r + SIG]),
                .sum_out (cell_sum[r])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.sum = cell_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_out = st_q.sum;

endmodule

// File: rtl/hankel_systolic_mul.sv
module hankel_systolic_mul #(
    parameter int D = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2*D-2:0]   hvec,
    input  logic [D-1:0]     bvec,
    output logic             out_valid,
    output logic [D-1:0]     prod
);

    localparam int HW = 2 * D - 1;
    localparam int OW = HW + D;

    typedef struct packed {
        logic [D-1:0] vld;
    } top_state_t;

    top_state_t            st_d;
    top_state_t            st_q;
    logic [D-1:0][OW-1:0]  op_taps;
    logic [D-1:0][D-1:0]   col_sum;

    hkl_skew #(
        .W     (OW),
        .DEPTH (D)
    ) u_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({hvec, bvec}),
        .taps  (op_taps)
    );

    generate
        for (genvar c = 0; c < D; c++) begin : g_col
            logic [D-1:0] sum_prev;
            if (c == 0) begin : g_first
                assign sum_prev = '0;
            end else begin : g_rest
                assign sum_prev = col_sum[c-1];
            end
            hkl_column #(
                .D   (D),
                .COL (c)
            ) u_col (
                .clk     (clk),
                .rst_n   (rst_n),
                .h_in    (op_taps[c][OW-1:D]),
                .b_in    (op_taps[c][D-1:0]),
                .sum_in  (sum_prev),
                .sum_out (col_sum[c])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.vld = {st_q.vld[D-2:0], in_valid};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld[D-1];
    assign prod      = col_sum[D-1];

endmodule

// File: rtl/hkl_checker.sv
module hkl_checker #(
    parameter int D = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        out_valid,
    input  logic [D-1:0]                prod,
    input  logic [D-1:0][3*D-2:0]       taps,
    input  logic [D-1:0][D-1:0]         col_sum
);

    localparam int CW = $clog2(D + 1);

    logic [CW-1:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= CW'(D);
        end else if (in_valid) begin
            quiet_q <= '0;
        end else if (quiet_q < CW'(D)) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (!out_valid && prod == '0); // R1
        end
    end

    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({out_valid, prod})); // R1

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q == CW'(D)) |-> !out_valid); // R5

    generate
        for (genvar c = 0; c < D; c++) begin : g_chk
            logic [D-1:0] prev_sum;
            if (c == 0) begin : g_first
                assign prev_sum = '0;
            end else begin : g_rest
                assign prev_sum = col_sum[c-1];
            end

            AST_ZERO_B_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(taps[c][D-1:0]) == '0) |-> (col_sum[c] == $past(prev_sum))); // R6

            AST_ZERO_H_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(taps[c][3*D-2:D]) == '0) |-> (col_sum[c] == $past(prev_sum))); // R7
        end
    endgenerate

endmodule

bind hankel_systolic_mul hkl_checker #(.D(D)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .prod      (prod),
    .taps      (op_taps),
    .col_sum   (col_sum)
);

// File: tb/hankel_systolic_mul_test.sv
module hankel_systolic_mul_test;

    localparam int D    = 8;
    localparam int HW   = 2 * D - 1;
    localparam int MAXC = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [HW-1:0] hvec = '0;
    logic [D-1:0]  bvec = '0;
    logic          out_valid;
    logic [D-1:0]  prod;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    bit           exp_v [MAXC];
    logic [D-1:0] exp_p [MAXC];
    string        exp_t [MAXC];

    always #2 clk = ~clk;

    hankel_systolic_mul #(.D(D)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .hvec      (hvec),
        .bvec      (bvec),
        .out_valid (out_valid),
        .prod      (prod)
    );

    function automatic logic [D-1:0] ref_prod(input logic [HW-1:0] h, input logic [D-1:0] b);
        logic [D-1:0] acc = '0;
        for (int i = 0; i < D; i++) begin
            for (int j = 0; j < D; j++) begin
                acc[i] = acc[i] ^ (h[i+j] & b[j]);
            end
        end
        return acc;
    endfunction

    // Compare outputs of the current cycle with the expectation scheduled D cycles ago.
    task automatic check_now();
        checks++;
        if (exp_v[cyc]) begin
            if (out_valid !== 1'b1 || prod !== exp_p[cyc]) begin
                errors++;
                $display("FAIL %s (R3 timing) cyc %0d: out_valid=%b prod=%h expected out_valid=1 prod=%h",
                         exp_t[cyc], cyc, out_valid, prod, exp_p[cyc]);
            end
        end else if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R5 cyc %0d: out_valid=%b expected 0", cyc, out_valid);
        end
    endtask

    task automatic step(input logic v, input logic [HW-1:0] h, input logic [D-1:0] b, input string tag);
        check_now();
        in_valid = v;
        hvec     = h;
        bvec     = b;
        if (v) begin
            exp_v[cyc+D] = 1'b1;
            exp_p[cyc+D] = ref_prod(h, b);
            exp_t[cyc+D] = tag;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic check_clear(input string tag);
        checks++;
        if (out_valid !== 1'b0 || prod !== '0) begin
            errors++;
            $display("FAIL %s: out_valid=%b prod=%h expected out_valid=0 prod=0", tag, out_valid, prod);
        end
    endtask

    initial begin
        logic [HW-1:0] hr;
        logic [D-1:0]  br;
        int            seed_sink;
        seed_sink = $urandom(32'h1A2B3C);

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check_clear("R1");
        end
        rst_n = 1'b1;

        // R1: idle after release with zero operands
        for (int k = 0; k < D + 2; k++) begin
            check_clear("R1");
            step(1'b0, '0, '0, "R1");
        end

        // Directed corner cases, back to back
        step(1'b1, '0, '0, "R6");
        step(1'b1, HW'($urandom), '0, "R6");
        step(1'b1, {HW{1'b1}}, '0, "R6");
        step(1'b1, '0, D'($urandom), "R7");
        step(1'b1, '0, {D{1'b1}}, "R7");
        step(1'b1, {HW{1'b1}}, {D{1'b1}}, "R8");
        step(1'b1, {HW{1'b1}}, D'(8'b0000_0111), "R8");
        step(1'b1, {HW{1'b1}}, D'(8'b1000_0001), "R8");

        // R9: single-bit sweep over both operands
        for (int k = 0; k < HW; k++) begin
            for (int j = 0; j < D; j++) begin
                step(1'b1, HW'(1) << k, D'(1) << j, "R9");
            end
        end

        // R2 / R4: dense random stream
        for (int k = 0; k < 300; k++) begin
            hr = HW'($urandom);
            br = D'($urandom);
            step(1'b1, hr, br, "R4");
        end

        // R5 / R2: random stream with gaps carrying random data
        for (int k = 0; k < 400; k++) begin
            hr = HW'($urandom);
            br = D'($urandom);
            step(1'($urandom % 2), hr, br, "R2");
        end

        // Drain
        for (int k = 0; k < D + 4; k++) begin
            step(1'b0, HW'($urandom), D'($urandom), "R5");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule